// File: doc/BRIEF.md
# Read Phase-Lock and Data-Offset Search Sequencer

This block drives the first two steps of read-path calibration for a DDR memory port. Each strobe group has a phase detector, and the sequencer puts all of them into calibration mode. It then issues a read on every clock, so the strobes toggle without a break. It stays in this stage until every group reports phase lock. It then drops calibration mode and moves to the data-offset search.

The search runs in trials. A trial is four reads with idle gaps between them, followed by a settle window. In the last cycle of that window the per-lane strobe-found flags are sampled. The trial passes only if every lane reports found. After a failed trial the offset moves by one memory clock and the next trial starts. The start point and the step direction depend on a bank-type parameter:

- **High-performance bank:** the search starts at CAS latency plus 13 and counts down.
- **High-range bank:** the search starts at CAS latency minus 2 and counts up.

A programmable trial limit and the range of the offset register bound the search. When the search succeeds, a done flag tells the next calibration stage it may begin. A host starts the sequence with a one-cycle pulse and acknowledges done.

Top module: `rd_lock_offset_cal`

## Requirements
- R1: After reset, rd_req, cal_mode, done and err are low and data_offset is 0.
- R2: While cal_mode is high, rd_req is high in every cycle, with no idle cycles between lock-stage reads.
- R3: The lock stage, and with it cal_mode, continues for as long as any bit of lock_in is low.
- R4: In the cycle after all lock_in bits are seen high, cal_mode is low and the first search trial begins.
- R5: Each trial is four single-cycle reads. GAP idle cycles separate the reads within a trial, and SETTLE idle cycles follow the fourth read. found_in is sampled in the last settle cycle.
- R6: With HP_BANK=1, the first trial uses data_offset = CAS_LAT+13, and each failed trial lowers it by exactly 1.
- R7: With HP_BANK=0, the first trial uses data_offset = CAS_LAT-2, and each failed trial raises it by exactly 1.
- R8: A trial passes only when every bit of found_in is high. done then rises, and data_offset keeps the passing value.
- R9: done stays high until done_ack is seen high. In the next cycle done is low and no reads are issued.
- R10: When the number of failed trials reaches trial_limit, err goes high. rd_req then stays low and data_offset stays frozen until the next start.
- R11: The offset never wraps. A failed trial at offset 0 (HP_BANK=1), or at the all-ones value of data_offset (HP_BANK=0), sets err instead of stepping. data_offset is $clog2(CAS_LAT+14) bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins calibration from idle, done-exit or error |
| trial_limit | input | LIM_W | Maximum number of failed search trials |
| lock_in | input | LANES | Per-group phase-lock status |
| found_in | input | LANES | Per-lane strobe-found status |
| done_ack | input | 1 | Acknowledge of done |
| rd_req | output | 1 | Read command request, one command per high cycle |
| cal_mode | output | 1 | Holds the phase detectors in calibration mode |
| data_offset | output | OFF_W | Current read data offset in memory clocks |
| done | output | 1 | Search passed; next stage may begin |
| err | output | 1 | Search stopped by trial limit or offset bound |

## Verification
A wrong trial counter or a wrong sub-state shows up at once in the pattern of rd_req. It would produce a missing read, an extra read, or an idle run that is neither GAP nor SETTLE long, and this is visible within one trial. A wrong offset register or step direction shows up as a wrong data_offset in the first search cycle, or as a final offset that differs from the lowest or highest passing value. A bad limit or bound check shows up as err rising one trial early or late, or as the offset wrapping past a bound, by the end of the run. The bench sweeps the passing offset across the whole range for both bank types at once, including targets that cannot be reached.

// File: rtl/rd_lock_offset_cal.sv
module rd_lock_offset_cal #(
  parameter int LANES   = 4,
  parameter int CAS_LAT = 11,
  parameter bit HP_BANK = 1'b1,
  parameter int GAP     = 3,
  parameter int SETTLE  = 8,
  parameter int LIM_W   = 8,
  localparam int OFF_W  = $clog2(CAS_LAT + 14)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LIM_W-1:0] trial_limit,
  input  logic [LANES-1:0] lock_in,
  input  logic [LANES-1:0] found_in,
  input  logic             done_ack,
  output logic             rd_req,
  output logic             cal_mode,
  output logic [OFF_W-1:0] data_offset,
  output logic             done,
  output logic             err
);
  localparam int CW = $clog2((GAP > SETTLE ? GAP : SETTLE) + 1);
  localparam logic [OFF_W-1:0] OFF_INIT = HP_BANK ? OFF_W'(CAS_LAT + 13) : OFF_W'(CAS_LAT - 2);
  localparam logic [CW-1:0] GAP_END = CW'(GAP - 1);
  localparam logic [CW-1:0] SET_END = CW'(SETTLE - 1);

  typedef enum logic [2:0] {S_IDLE, S_LOCK, S_RD, S_GAP, S_SETL, S_DONE, S_ERR} st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [1:0]       rd_n;
  logic [LIM_W-1:0] fails;
  logic [OFF_W-1:0] off;

  wire all_found = &found_in;
  wire at_bound  = HP_BANK ? (off == '0) : (off == '1);
  wire last_try  = ({1'b0, fails} + 1'b1) >= {1'b0, trial_limit};
  wire [OFF_W-1:0] off_next = HP_BANK ? off - 1'b1 : off + 1'b1;

  assign rd_req      = (st == S_LOCK) || (st == S_RD);
  assign cal_mode    = (st == S_LOCK);
  assign done        = (st == S_DONE);
  assign err         = (st == S_ERR);
  assign data_offset = off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      rd_n  <= '0;
      fails <= '0;
      off   <= '0;
    end else begin
      case (st)
        S_IDLE, S_ERR: if (start) begin
          st    <= S_LOCK;
          off   <= OFF_INIT;
          fails <= '0;
          rd_n  <= '0;
        end
        S_LOCK: if (&lock_in) st <= S_RD;
        S_RD: begin
          cnt  <= '0;
          rd_n <= rd_n + 1'b1;
          st   <= (rd_n == 2'd3) ? S_SETL : S_GAP;
        end
        S_GAP: if (cnt == GAP_END) st <= S_RD;
               else cnt <= cnt + 1'b1;
        S_SETL: if (cnt == SET_END) begin
          if (all_found) st <= S_DONE;
          else if (last_try || at_bound) st <= S_ERR;
          else begin
            off   <= off_next;
            fails <= fails + 1'b1;
            st    <= S_RD;
          end
        end else cnt <= cnt + 1'b1;
        S_DONE: if (done_ack) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module rd_lock_offset_cal_chk #(
  parameter int LANES   = 4,
  parameter bit HP_BANK = 1'b1,
  parameter int OFF_W   = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [LANES-1:0] lock_in,
  input logic [LANES-1:0] found_in,
  input logic             done_ack,
  input logic             rd_req,
  input logic             cal_mode,
  input logic [OFF_W-1:0] data_offset,
  input logic             done,
  input logic             err
);
  p_lock_reads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cal_mode |-> rd_req);

  p_lock_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cal_mode) |-> $past(&lock_in));

  p_offset_step_r6_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cal_mode && $past(!cal_mode) && (data_offset != $past(data_offset)))
      |-> (data_offset == (HP_BANK ? $past(data_offset) - OFF_W'(1)
                                   : $past(data_offset) + OFF_W'(1))));

  p_pass_all_lanes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(&found_in));

  p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_ack) |=> done);

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!rd_req && !err));

  p_err_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start) |=> ($stable(data_offset) && !rd_req));
endmodule

bind rd_lock_offset_cal rd_lock_offset_cal_chk #(
  .LANES(LANES), .HP_BANK(HP_BANK), .OFF_W(OFF_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .lock_in(lock_in),
  .found_in(found_in), .done_ack(done_ack), .rd_req(rd_req),
  .cal_mode(cal_mode), .data_offset(data_offset), .done(done), .err(err)
);

// File: tb/rd_lock_offset_cal_test.sv
module rd_lock_offset_cal_test;
  localparam int CLK_NS = 10;
  localparam int LANES = 4, CL = 11, GAP = 3, SETTLE = 8, LIM_W = 8;
  localparam int OFF_W = $clog2(CL + 14);
  localparam int OFF_MAX = (1 << OFF_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, done_ack = 1'b0;
  logic [LIM_W-1:0] trial_limit = '1;
  logic [LANES-1:0] lock_in = '0, found_hp, found_hr;
  logic rd_hp, cal_hp, done_hp, err_hp, rd_hr, cal_hr, done_hr, err_hr;
  logic [OFF_W-1:0] off_hp, off_hr;
  int t_hp = 0, t_hr = 0;
  int checks = 0, errors = 0;

  always #(CLK_NS/2) clk = ~clk;

  rd_lock_offset_cal #(.LANES(LANES), .CAS_LAT(CL), .HP_BANK(1'b1), .GAP(GAP),
    .SETTLE(SETTLE), .LIM_W(LIM_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .trial_limit(trial_limit),
    .lock_in(lock_in), .found_in(found_hp), .done_ack(done_ack),
    .rd_req(rd_hp), .cal_mode(cal_hp), .data_offset(off_hp), .done(done_hp), .err(err_hp));

  rd_lock_offset_cal #(.LANES(LANES), .CAS_LAT(CL), .HP_BANK(1'b0), .GAP(GAP),
    .SETTLE(SETTLE), .LIM_W(LIM_W)) uut_hr (
    .clk(clk), .rst_n(rst_n), .start(start), .trial_limit(trial_limit),
    .lock_in(lock_in), .found_in(found_hr), .done_ack(done_ack),
    .rd_req(rd_hr), .cal_mode(cal_hr), .data_offset(off_hr), .done(done_hr), .err(err_hr));

  always_comb
    for (int i = 0; i < LANES; i++) begin
      found_hp[i] = int'(off_hp) <= t_hp + i;
      found_hr[i] = int'(off_hr) >= t_hr - i;
    end

  // read monitor: counts search reads and checks idle-run lengths (R5), lock continuity (R2)
  int rd_cnt_hp, rd_cnt_hr, bad_hp, bad_hr, idle_hp, idle_hr, lock_bad;
  bit seen_hp, seen_hr;
  always @(negedge clk) if (rst_n) begin
    if ((cal_hp && !rd_hp) || (cal_hr && !rd_hr)) lock_bad++;
    if (!cal_hp && rd_hp) begin
      if (seen_hp && idle_hp != GAP && idle_hp != SETTLE) bad_hp++;
      rd_cnt_hp++; seen_hp = 1; idle_hp = 0;
    end else if (seen_hp && !cal_hp) idle_hp++;
    if (!cal_hr && rd_hr) begin
      if (seen_hr && idle_hr != GAP && idle_hr != SETTLE) bad_hr++;
      rd_cnt_hr++; seen_hr = 1; idle_hr = 0;
    end else if (seen_hr && !cal_hr) idle_hr++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input int k, input int lim);
    int exp_off_hp, exp_off_hr, tr_hp, tr_hr;
    bit pass_hp, pass_hr;
    t_hp = (CL + 13) - k;
    t_hr = (CL - 2) + k;
    trial_limit = LIM_W'(lim);
    pass_hp = t_hp >= 0;
    tr_hp = pass_hp ? k + 1 : CL + 14;
    exp_off_hp = pass_hp ? t_hp : 0;
    pass_hr = t_hr <= OFF_MAX;
    tr_hr = pass_hr ? k + 1 : OFF_MAX - (CL - 2) + 1;
    exp_off_hr = pass_hr ? t_hr : OFF_MAX;
    if (tr_hp > lim) begin pass_hp = 0; tr_hp = lim; exp_off_hp = CL + 13 - (lim - 1); end
    if (tr_hr > lim) begin pass_hr = 0; tr_hr = lim; exp_off_hr = CL - 2 + (lim - 1); end

    @(negedge clk); lock_in = '0; start = 1'b1;
    rd_cnt_hp = 0; rd_cnt_hr = 0; bad_hp = 0; bad_hr = 0; lock_bad = 0;
    seen_hp = 0; seen_hr = 0; idle_hp = 0; idle_hr = 0;
    @(negedge clk); start = 1'b0;
    chk(cal_hp && cal_hr && rd_hp && rd_hr, "R2 lock entry", int'(cal_hp), 1);
    repeat (4) @(negedge clk);
    for (int i = 0; i < LANES - 1; i++) begin lock_in[i] = 1'b1; repeat (2) @(negedge clk); end
    chk(cal_hp && cal_hr, "R3 partial lock holds cal_mode", int'(cal_hr), 1);
    lock_in[LANES-1] = 1'b1;
    @(negedge clk);
    chk(!cal_hp && !cal_hr, "R4 cal_mode released", int'(cal_hp), 0);
    chk(int'(off_hp) == CL + 13, "R6 HP initial offset", int'(off_hp), CL + 13);
    chk(int'(off_hr) == CL - 2, "R7 HR initial offset", int'(off_hr), CL - 2);
    chk(lock_bad == 0, "R2 reads every lock cycle", lock_bad, 0);
    while (!((done_hp || err_hp) && (done_hr || err_hr))) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(done_hp == pass_hp && err_hp == !pass_hp, "R8 R10 R11 HP outcome", int'(done_hp), int'(pass_hp));
    chk(done_hr == pass_hr && err_hr == !pass_hr, "R8 R10 R11 HR outcome", int'(done_hr), int'(pass_hr));
    chk(int'(off_hp) == exp_off_hp, "R6 HP final offset", int'(off_hp), exp_off_hp);
    chk(int'(off_hr) == exp_off_hr, "R7 HR final offset", int'(off_hr), exp_off_hr);
    chk(rd_cnt_hp == 4 * tr_hp, "R5 HP read count", rd_cnt_hp, 4 * tr_hp);
    chk(rd_cnt_hr == 4 * tr_hr, "R5 HR read count", rd_cnt_hr, 4 * tr_hr);
    chk(bad_hp == 0 && bad_hr == 0, "R5 read spacing", bad_hp + bad_hr, 0);
    done_ack = 1'b1;
    @(negedge clk); done_ack = 1'b0;
    chk(!done_hp && !done_hr && !rd_hp && !rd_hr, "R9 done cleared by ack", int'(done_hp | done_hr), 0);
    chk(err_hp == !pass_hp && err_hr == !pass_hr, "R10 err held", int'(err_hp), int'(!pass_hp));
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rd_hp && !cal_hp && !done_hp && !err_hp && off_hp == '0, "R1 reset HP", int'(rd_hp | cal_hp), 0);
    chk(!rd_hr && !cal_hr && !done_hr && !err_hr && off_hr == '0, "R1 reset HR", int'(rd_hr | cal_hr), 0);
    for (int k = 0; k <= CL + 14; k++) run(k, 255);
    run(10, 3);
    run(0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule